// File: doc/BRIEF.md
# UART Transmitter with Clear-to-Send Gating

This block serialises characters onto an asynchronous transmit line. A write strobe puts a character into a one-entry holding buffer. When the output shift register is free, the character moves into it and a frame begins. Because of this double buffering, the next character can be written while the current frame is still on the line. The frame shape is set by the configuration inputs, which are sampled at the moment a character is loaded:

- a start bit;
- 7, 8 or 9 data bits, least significant first;
- an optional even or odd parity bit;
- one or two stop bits.

The bit period is taken from a divider that counts strobes of a selectable count source. The strobes themselves are generated outside the block.

A clear-to-send input can be switched in to hold the line between frames. It is an active-low input and passes through a synchroniser. While it is high, no new frame starts. The frame already on the line always runs to its last stop bit. When the input drops low again, transmission resumes at once.

An interrupt request is raised in one of two ways, chosen by a mode input: on every transfer from the buffer into the shift register, or when the line goes idle with nothing left to send. The request stays set until it is acknowledged. Status outputs report an empty holding buffer and a fully empty transmitter.

Top module: `uart_tx_cts`

## Requirements
- R1: After reset, txd is 1, irq is 0, buf_empty is 1 and tx_empty is 1.
- R2: Each bit lasts 16*(brg_div+1) strobes of the count source picked by src_sel, where src_sel is an index into src_tick.
- R3: A frame has the following bits in order:
  - a 0 start bit;
  - the data bits, bit 0 first; len_sel 0 gives 7 bits, 2 gives 9 bits, and 1 or 3 gives 8 bits;
  - the parity bit, when par_en=1;
  - one stop bit of 1, or two when two_stop=1.
- R4: With par_odd=0 the data bits and the parity bit together hold an even number of ones. With par_odd=1 they hold an odd number.
- R5: A write sets buf_empty to 0. The character is loaded into the shift register on the first clock edge at which the register is free, tx_en=1 and sending is allowed. buf_empty is 1 from that edge. A character waiting in the buffer starts its start bit directly after the previous frame's last stop bit, with no idle time between the two frames.
- R6: With cts_en=1, a cts_n level that has been 1 for two clock edges stops the next frame from starting. The frame in progress completes. The held frame starts on the third edge after cts_n falls to 0.
- R7: With cts_en=0, cts_n has no effect on when frames start.
- R8: With irq_on_done=0, irq is set by the edge that loads a character into the shift register.
- R9: With irq_on_done=1, irq is set by the edge that ends the last stop bit, if the holding buffer is empty at that moment. It stays 0 while a frame is being sent.
- R10: Once irq is set, it stays at 1 until irq_ack is 1 at an edge where no new set occurs.
- R11: With tx_en=0, no new frame starts, the frame in progress completes, and txd stays at 1 while no frame is in progress.
- R12: tx_empty is 1 only when the holding buffer is empty and no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_tick | input | NSRC | Count-source strobes, one per source |
| src_sel | input | SEL_W | Index of the count source to use |
| brg_div | input | DIV_W | Divider value n |
| len_sel | input | 2 | Data length code |
| par_en | input | 1 | Parity bit enable |
| par_odd | input | 1 | Odd parity when 1, even when 0 |
| two_stop | input | 1 | Two stop bits when 1 |
| tx_en | input | 1 | Transmit enable |
| cts_en | input | 1 | Clear-to-send gating enable |
| irq_on_done | input | 1 | Interrupt mode: 1 = line idle, 0 = buffer transfer |
| wr_stb | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 9 | Character to write |
| cts_n | input | 1 | Clear-to-send input, active low |
| irq_ack | input | 1 | Clears the interrupt request |
| txd | output | 1 | Serial output line |
| irq | output | 1 | Interrupt request flag |
| buf_empty | output | 1 | Holding buffer is empty |
| tx_empty | output | 1 | Holding buffer and shift register are both empty |

## Verification
The main function is run with several input patterns:

- Single frames with a distinct data pattern for each length (7, 8 and 9 bits) and parity setting. These separate bit-order, length and parity faults.
- Two characters queued back to back. This exposes any idle gap or lost character at the buffer handoff.
- Slow count sources: a strobe on every third clock and an irregular external strobe. These show that the divider counts strobes and not clocks.
- Clear-to-send raised in the middle of a frame and then released, run once with gating on and once with gating off. This separates "frame completes, then holds" from "ignores the input".
- Transmit enable dropped with a character still pending, and both interrupt modes with delayed acknowledges. These tell the two request conditions apart and show that the flag is sticky.

// File: rtl/utx_pkg.sv
package utx_pkg;

    localparam int MAX_DATA = 9;
    localparam int FRAME_W  = 1 + MAX_DATA + 1 + 2;
    localparam int LEN_W    = $clog2(FRAME_W + 1);

    typedef enum logic [1:0] {
        LEN_7  = 2'd0,
        LEN_8  = 2'd1,
        LEN_9  = 2'd2,
        LEN_8X = 2'd3
    } len_code_e;

    typedef struct packed {
        len_code_e len;
        logic      par_en;
        logic      par_odd;
        logic      two_stop;
    } fmt_t;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [LEN_W-1:0]   len;
    } frame_t;

    function automatic int data_count(input len_code_e c);
        case (c)
            LEN_7:   return 7;
            LEN_9:   return 9;
            default: return 8;
        endcase
    endfunction

    // Bit 0 of the result goes out first; unused upper bits are 1 (stop level).
    function automatic frame_t build_frame(input logic [MAX_DATA-1:0] d, input fmt_t f);
        frame_t r;
        int     n;
        logic   p;
        n      = data_count(f.len);
        p      = f.par_odd;
        r.bits = '1;
        r.bits[0] = 1'b0;
        for (int i = 0; i < MAX_DATA; i++) begin
            if (i < n) begin
                r.bits[1+i] = d[i];
                p = p ^ d[i];
            end
        end
        if (f.par_en) r.bits[1+n] = p;
        r.len = LEN_W'(n + 2 + int'(f.par_en) + int'(f.two_stop));
        return r;
    endfunction

endpackage

// File: rtl/utx_baud.sv
module utx_baud #(
    parameter int NSRC  = 4,
    parameter int DIV_W = 8,
    localparam int SEL_W = $clog2(NSRC),
    localparam int CNT_W = DIV_W + 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [NSRC-1:0]  src_tick,
    input  logic [SEL_W-1:0] src_sel,
    input  logic [DIV_W-1:0] div,
    output logic             bit_end
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;
    logic             tick;

    assign tick    = src_tick[src_sel];
    assign limit   = {div, 4'hF};
    assign bit_end = run && tick && (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= (cnt == limit) ? '0 : cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/utx_cts_sync.sv
module utx_cts_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) sr <= '1;
        else     sr <= {sr[STAGES-2:0], d_in};
    end

    assign d_out = sr[STAGES-1];
endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
    import utx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  frame_t frame_in,
    input  logic   bit_end,
    output logic   busy,
    output logic   last,
    output logic   line
);
    logic [FRAME_W-1:0] sh_q;
    logic [LEN_W-1:0]   left;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '1;
            left <= '0;
            busy <= 1'b0;
        end else if (load) begin
            sh_q <= frame_in.bits;
            left <= frame_in.len;
            busy <= 1'b1;
        end else if (busy && bit_end) begin
            sh_q <= {1'b1, sh_q[FRAME_W-1:1]};
            left <= left - LEN_W'(1);
            if (left == LEN_W'(1)) busy <= 1'b0;
        end
    end

    assign last = (left == LEN_W'(1));
    assign line = busy ? sh_q[0] : 1'b1;
endmodule

// File: rtl/uart_tx_cts.sv
module uart_tx_cts
    import utx_pkg::*;
#(
    parameter int NSRC       = 4,
    parameter int DIV_W      = 8,
    parameter int CTS_STAGES = 2,
    localparam int SEL_W     = $clog2(NSRC)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NSRC-1:0]     src_tick,
    input  logic [SEL_W-1:0]    src_sel,
    input  logic [DIV_W-1:0]    brg_div,
    input  logic [1:0]          len_sel,
    input  logic                par_en,
    input  logic                par_odd,
    input  logic                two_stop,
    input  logic                tx_en,
    input  logic                cts_en,
    input  logic                irq_on_done,
    input  logic                wr_stb,
    input  logic [MAX_DATA-1:0] wr_data,
    input  logic                cts_n,
    input  logic                irq_ack,
    output logic                txd,
    output logic                irq,
    output logic                buf_empty,
    output logic                tx_empty
);
    logic                hold_full;
    logic [MAX_DATA-1:0] hold_q;
    logic                cts_sync;
    logic                sh_busy, sh_last, bit_end;
    logic                frame_done, slot_free, cts_ok, load, irq_set, irq_q;
    fmt_t                fmt;
    frame_t              nxt_frame;

    utx_baud #(.NSRC(NSRC), .DIV_W(DIV_W)) i_baud (
        .clk(clk), .rst(rst), .run(sh_busy), .src_tick(src_tick),
        .src_sel(src_sel), .div(brg_div), .bit_end(bit_end)
    );

    utx_cts_sync #(.STAGES(CTS_STAGES)) i_sync (
        .clk(clk), .rst(rst), .d_in(cts_n), .d_out(cts_sync)
    );

    assign fmt       = '{len: len_code_e'(len_sel), par_en: par_en,
                         par_odd: par_odd, two_stop: two_stop};
    assign nxt_frame = build_frame(hold_q, fmt);

    assign frame_done = sh_busy && bit_end && sh_last;
    assign slot_free  = !sh_busy || frame_done;
    assign cts_ok     = !cts_en || !cts_sync;
    assign load       = slot_free && hold_full && tx_en && cts_ok;
    assign irq_set    = irq_on_done ? (frame_done && !hold_full) : load;

    utx_shifter i_shift (
        .clk(clk), .rst(rst), .load(load), .frame_in(nxt_frame),
        .bit_end(bit_end), .busy(sh_busy), .last(sh_last), .line(txd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_full <= 1'b0;
            hold_q    <= '0;
        end else if (wr_stb) begin
            hold_full <= 1'b1;
            hold_q    <= wr_data;
        end else if (load) begin
            hold_full <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          irq_q <= 1'b0;
        else if (irq_set) irq_q <= 1'b1;
        else if (irq_ack) irq_q <= 1'b0;
    end

    assign irq       = irq_q;
    assign buf_empty = !hold_full;
    assign tx_empty  = !hold_full && !sh_busy;
endmodule

// File: rtl/uart_tx_cts_chk.sv
module uart_tx_cts_chk (
    input logic clk,
    input logic rst,
    input logic txd,
    input logic irq,
    input logic irq_ack,
    input logic buf_empty,
    input logic tx_empty,
    input logic cts_en,
    input logic cts_s,
    input logic busy
);
    assert_empty_status_R12: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> (buf_empty && txd));

    assert_idle_high_R11: assert property (@(posedge clk) disable iff (rst)
        !busy |-> txd);

    assert_load_starts_frame_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(buf_empty) |-> (busy && !txd));

    assert_cts_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (cts_en && cts_s && !busy) |=> !busy);

    assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_ack) |=> irq);
endmodule

bind uart_tx_cts uart_tx_cts_chk i_chk (
    .clk(clk), .rst(rst), .txd(txd), .irq(irq), .irq_ack(irq_ack),
    .buf_empty(buf_empty), .tx_empty(tx_empty), .cts_en(cts_en),
    .cts_s(cts_sync), .busy(sh_busy)
);

// File: tb/test_uart_tx_cts.sv
`timescale 1ns/1ps
module test_uart_tx_cts;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] src_tick = 4'b0001;
    logic [1:0] src_sel = 2'd0;
    logic [7:0] brg = 8'd0;
    logic [1:0] len_sel = 2'd1;
    logic       par_en = 0, par_odd = 0, two_stop = 0, tx_en = 1;
    logic       cts_en = 0, irq_on_done = 0, wr_stb = 0, cts_n = 0, irq_ack = 0;
    logic [8:0] wr_data = '0;
    logic       txd, irq, buf_empty, tx_empty;

    int    n_chk = 0, n_fail = 0, cyc = 0;
    string cur_req = "R3";

    uart_tx_cts i_uart_tx_cts (
        .clk(clk), .rst(rst), .src_tick(src_tick), .src_sel(src_sel),
        .brg_div(brg), .len_sel(len_sel), .par_en(par_en), .par_odd(par_odd),
        .two_stop(two_stop), .tx_en(tx_en), .cts_en(cts_en),
        .irq_on_done(irq_on_done), .wr_stb(wr_stb), .wr_data(wr_data),
        .cts_n(cts_n), .irq_ack(irq_ack), .txd(txd), .irq(irq),
        .buf_empty(buf_empty), .tx_empty(tx_empty)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    // count-source strobes: every clock, every 3rd, every 5th, irregular external
    always @(negedge clk) begin
        cyc++;
        src_tick = {((cyc % 7 == 0) || (cyc % 11 == 0)), (cyc % 5 == 0), (cyc % 3 == 0), 1'b1};
    end

    // behavioural reference model
    bit       q[$];
    int       m_cnt;
    bit       m_full, m_irq, m_c1, m_c2;
    bit [8:0] m_buf;
    bit       m_tick, m_ok, m_was, m_done, m_ld, m_set;

    function automatic void push_frame(input bit [8:0] d);
        int n;
        int ones;
        n = (len_sel == 2'd0) ? 7 : (len_sel == 2'd2) ? 9 : 8;
        ones = 0;
        q.push_back(1'b0);
        for (int i = 0; i < n; i++) begin
            q.push_back(d[i]);
            ones += int'(d[i]);
        end
        if (par_en) q.push_back(par_odd ? ((ones % 2) == 0) : ((ones % 2) == 1));
        q.push_back(1'b1);
        if (two_stop) q.push_back(1'b1);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            q.delete(); m_cnt = 0; m_full = 0; m_irq = 0; m_c1 = 1; m_c2 = 1; m_buf = '0;
        end else begin
            m_tick = src_tick[src_sel];
            m_ok   = !cts_en || !m_c2;
            m_was  = q.size() > 0;
            m_done = 0;
            if (m_was && m_tick) begin
                if (m_cnt == 16 * (int'(brg) + 1) - 1) begin
                    m_cnt = 0;
                    q.delete(0);
                    m_done = (q.size() == 0);
                end else m_cnt++;
            end
            if (!m_was) m_cnt = 0;
            m_ld  = (q.size() == 0) && m_full && tx_en && m_ok;
            m_set = irq_on_done ? (m_done && !m_full) : m_ld;
            if (m_ld) push_frame(m_buf);
            if (wr_stb) begin m_full = 1; m_buf = wr_data; end
            else if (m_ld) m_full = 0;
            if (m_set) m_irq = 1;
            else if (irq_ack) m_irq = 0;
            m_c2 = m_c1; m_c1 = cts_n;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk(txd === ((q.size() > 0) ? q[0] : 1'b1), cur_req, "txd", int'(txd),
                int'((q.size() > 0) ? q[0] : 1'b1));
            chk(buf_empty === !m_full, "R5", "buf_empty", int'(buf_empty), int'(!m_full));
            chk(tx_empty === (!m_full && q.size() == 0), "R12", "tx_empty", int'(tx_empty),
                int'(!m_full && q.size() == 0));
            chk(irq === m_irq, irq_on_done ? "R9" : "R8", "irq", int'(irq), int'(m_irq));
        end
    end

    task automatic write_char(input logic [8:0] d);
        @(negedge clk); wr_stb = 1; wr_data = d;
        @(negedge clk); wr_stb = 0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!tx_empty) @(negedge clk);
    endtask

    task automatic ack();
        @(negedge clk); irq_ack = 1;
        @(negedge clk); irq_ack = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        int lowc;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(txd === 1'b1, "R1", "reset txd", int'(txd), 1);
        chk(irq === 1'b0, "R1", "reset irq", int'(irq), 0);
        chk(buf_empty === 1'b1, "R1", "reset buf_empty", int'(buf_empty), 1);
        chk(tx_empty === 1'b1, "R1", "reset tx_empty", int'(tx_empty), 1);

        // R2: start bit length with divider 2 on the every-clock source
        cur_req = "R2"; brg = 8'd2;
        write_char(9'h0FF);
        while (txd) @(negedge clk);
        lowc = 0;
        while (!txd) begin lowc++; @(negedge clk); end
        chk(lowc == 48, "R2", "start bit clocks", lowc, 48);
        wait_idle();

        // R3/R5: 8 data bits, two stops, back-to-back queueing
        cur_req = "R3"; brg = 8'd0; two_stop = 1;
        write_char(9'h05A);
        while (!buf_empty) @(negedge clk);
        chk(tx_empty === 1'b0, "R12", "tx_empty during frame", int'(tx_empty), 0);
        cur_req = "R5";
        write_char(9'h03C);
        wait_idle();
        two_stop = 0;

        // R4: 7-bit even, then 9-bit odd on the divide-by-3 source
        cur_req = "R4"; len_sel = 2'd0; par_en = 1; par_odd = 0;
        write_char(9'h06B);
        wait_idle();
        len_sel = 2'd2; par_odd = 1; brg = 8'd1; src_sel = 2'd1;
        write_char(9'h1A5);
        wait_idle();
        len_sel = 2'd1; par_en = 0; brg = 8'd0; src_sel = 2'd0;

        // R8/R10: transfer-mode interrupt and stickiness
        cur_req = "R8"; ack();
        write_char(9'h0C3);
        @(negedge clk);
        chk(irq === 1'b1, "R8", "irq after load", int'(irq), 1);
        repeat (50) @(negedge clk);
        chk(irq === 1'b1, "R10", "irq held without ack", int'(irq), 1);
        ack();
        chk(irq === 1'b0, "R10", "irq after ack", int'(irq), 0);
        wait_idle();

        // R9: completion-mode interrupt
        cur_req = "R9"; irq_on_done = 1; ack();
        write_char(9'h081);
        repeat (20) @(negedge clk);
        chk(irq === 1'b0, "R9", "irq mid-frame", int'(irq), 0);
        wait_idle();
        chk(irq === 1'b1, "R9", "irq at idle", int'(irq), 1);
        ack();

        // R6: CTS raised mid-frame holds the next frame
        cur_req = "R6"; cts_en = 1; cts_n = 0;
        write_char(9'h011);
        while (!buf_empty) @(negedge clk);
        write_char(9'h022);
        cts_n = 1;
        repeat (400) @(negedge clk);
        chk(txd === 1'b1, "R6", "txd while held", int'(txd), 1);
        chk(buf_empty === 1'b0, "R6", "char still pending", int'(buf_empty), 0);
        chk(tx_empty === 1'b0, "R6", "tx_empty while held", int'(tx_empty), 0);
        cts_n = 0;
        repeat (3) @(negedge clk);
        chk(txd === 1'b0, "R6", "start bit after release", int'(txd), 0);
        wait_idle();

        // R7: CTS ignored when gating is off
        cur_req = "R7"; cts_en = 0; cts_n = 1;
        write_char(9'h033);
        @(negedge clk);
        chk(txd === 1'b0, "R7", "start with cts_n high", int'(txd), 0);
        wait_idle();
        cts_n = 0;

        // R11: disable with a character pending
        cur_req = "R11";
        write_char(9'h044);
        while (!buf_empty) @(negedge clk);
        write_char(9'h055);
        tx_en = 0;
        repeat (400) @(negedge clk);
        chk(txd === 1'b1, "R11", "txd idle when disabled", int'(txd), 1);
        chk(buf_empty === 1'b0, "R11", "pending kept", int'(buf_empty), 0);
        tx_en = 1;
        wait_idle();

        // R2: irregular external count source
        cur_req = "R2"; src_sel = 2'd3;
        write_char(9'h0E7);
        wait_idle();
        repeat (5) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule